// File: doc/BRIEF.md
# DDR Auto-Refresh Scheduler

This block keeps a four-bank DDR SDRAM refreshed on behalf of a memory controller. A free-running interval timer adds one refresh obligation per average refresh interval to a credit counter. When enough obligations have piled up, the block asks the command arbiter for a precharge-all and then an auto-refresh. It then blocks activates until the refresh cycle time has elapsed. The arbiter may postpone the request. After eight postponed obligations the block flags the request as urgent, and further interval ticks are dropped. When the controller reports idle cycles, they may pay the credit down to zero early.

The block also walks the device into and out of self-refresh. A level request closes all banks and issues a refresh with the clock enable low. It holds the clock enable low for as long as the request stays high. When the request drops, the block raises the clock enable and clears the credit. It restarts the interval timer and keeps separate hold-offs for non-read commands and for reads. Every timing is a parameter in nanoseconds or cycles, converted with a clock-period parameter.

The arbiter takes the command lines only in a cycle where it asserts the grant while the request is high.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While the block is not in self-refresh, `owed_o` rises by one every `REFI_CYC` cycles. `REFI_CYC` is the refresh interval divided by the clock period, rounded down: 390 at 7.8 us and 20 ns. After reset the first increment is visible `REFI_CYC` cycles after the first active edge.
- R2: `owed_o` never exceeds `MAX_OWED` (8). A tick that arrives at 8 is dropped. `urgent_o` is high exactly when `owed_o` equals 8.
- R3: In the idle state with `owed_o` at least `LAZY_LEVEL` (4), the block raises `req_o` with the precharge-all encoding. That encoding is cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1.
- R4: After the precharge grant, the refresh request (cs_n=0, ras_n=0, cas_n=0, we_n=1, a10=0) is raised `RP_CYC` cycles later. `RP_CYC` is the precharge period rounded up to whole cycles. A grant offered earlier than that has no effect.
- R5: A granted auto-refresh lowers `owed_o` by one. If an interval tick falls in the same cycle, `owed_o` keeps its value.
- R6: `hold_act_o` is high while the refresh request is pending. It stays high for the `RFC_CYC-1` cycles that follow an auto-refresh grant (`RFC_CYC` = refresh cycle time rounded up). No new request appears before `RFC_CYC` cycles have passed.
- R7: With `idle_i` high, any nonzero `owed_o` starts a refresh sequence, so the credit drains to zero. With `owed_o` at zero, no request is raised.
- R8: Once raised, `req_o` and the command lines hold steady until granted. With `req_o` low, the command lines read cs_n=ras_n=cas_n=we_n=1 and a10=0.
- R9: When `sr_want_i` is high, the block issues a precharge-all and then a refresh. `cke_o` is low in that refresh's grant cycle and stays low, with `req_o` low, until `sr_want_i` drops.
- R10: `cke_o` returns high in the cycle after `sr_want_i` is seen low in self-refresh. From that cycle `hold_act_o` stays high for `XSNR_CYC` (4) cycles and `hold_rd_o` stays high for `XSRD_CYC` (200) cycles.
- R11: On self-refresh exit `owed_o` is zero. The interval timer restarts, so `owed_o` first becomes 1 exactly `REFI_CYC` cycles after `cke_o` returns high. The timer is frozen during self-refresh.
- R12: A pending self-refresh request takes precedence over an auto-refresh start in the idle state. No sequence starts while the non-read exit window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Arbiter accepts the command on the lines this cycle |
| idle_i | input | 1 | Controller has no traffic; refresh may be paid early |
| sr_want_i | input | 1 | Level request to be in self-refresh |
| req_o | output | 1 | Command request to the arbiter |
| urgent_o | output | 1 | Credit full; refresh must win arbitration |
| cmd_cs_n_o | output | 1 | Requested command, chip select (low active) |
| cmd_ras_n_o | output | 1 | Requested command, row strobe |
| cmd_cas_n_o | output | 1 | Requested command, column strobe |
| cmd_we_n_o | output | 1 | Requested command, write enable |
| cmd_a10_o | output | 1 | Address bit 10 (all-bank select on precharge) |
| cke_o | output | 1 | Clock enable to the devices |
| hold_act_o | output | 1 | Activates and other non-read commands forbidden |
| hold_rd_o | output | 1 | Reads forbidden |
| owed_o | output | clog2(MAX_OWED+1) | Number of postponed refreshes |

## Verification
The interval tick and an auto-refresh grant can land in the same cycle, and the credit counter must then neither step up nor down. The bench provokes this with an arbiter mode that grants the precharge at once but holds back the refresh grant until the interval timer's last count. It then checks over several intervals that the credit stays at four. A second collision is a self-refresh request while the credit is above the lazy level. It is judged by seeing the clock enable fall on the refresh grant while the credit is unchanged.

// File: rtl/ddr_refresh_sched_pkg.sv
// Shared types for the refresh scheduler: controller states and the
// command-line bundle with the two command encodings it issues.
package ddr_refresh_sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE_AR = 3'd1,
        ST_REF_AR = 3'd2,
        ST_RFC    = 3'd3,
        ST_PRE_SR = 3'd4,
        ST_ENT_SR = 3'd5,
        ST_SELF   = 3'd6
    } rs_state_e;

    // Bit order: cs_n, ras_n, cas_n, we_n, a10.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_DESEL  = 5'b11110;
    localparam ddr_cmd_t CMD_PREALL = 5'b00101;
    localparam ddr_cmd_t CMD_AREF   = 5'b00010;

endpackage

// File: rtl/refi_timer.sv
// Interval timer: pulses tick once every REFI_CYC cycles.
// Assumes REFI_CYC >= 2. While hold is high the count is forced to zero,
// so releasing hold restarts a full interval.
module refi_timer #(
    parameter int REFI_CYC = 390
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int TW = $clog2(REFI_CYC + 1);

    logic [TW-1:0] cnt_q;

    assign tick = !hold && (cnt_q == TW'(REFI_CYC - 1));

    // Count cycles of the current interval, wrapping on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/owed_counter.sv
// Credit of postponed refreshes. Adds on inc, subtracts on dec,
// saturates at MAX_OWED, clear has priority over both.
module owed_counter #(
    parameter int MAX_OWED = 8,
    localparam int OW      = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    input  logic          dec,
    output logic [OW-1:0] owed
);
    logic at_max;
    logic do_dec;

    assign at_max = (owed == OW'(MAX_OWED));
    assign do_dec = dec && (owed != '0);

    // Track the credit; a tick and a decrement in one cycle cancel.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            owed <= '0;
        end else if (inc && !do_dec) begin
            if (!at_max) begin
                owed <= owed + 1'b1;
            end
        end else if (do_dec && !inc) begin
            owed <= owed - 1'b1;
        end
    end
endmodule

// File: rtl/exit_window.sv
// Self-refresh exit hold-offs. start loads zero in the cycle before the
// clock enable rises; the count then runs to XSRD_CYC and stops.
// Assumes XSNR_CYC <= XSRD_CYC. Idles released after reset.
module exit_window #(
    parameter int XSNR_CYC = 4,
    parameter int XSRD_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_nonrd,
    output logic busy_rd
);
    localparam int XW = $clog2(XSRD_CYC + 1);

    logic [XW-1:0] xs_q;

    assign busy_nonrd = (xs_q < XW'(XSNR_CYC));
    assign busy_rd    = (xs_q < XW'(XSRD_CYC));

    // Count cycles since the clock enable came back, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xs_q <= XW'(XSRD_CYC);
        end else if (start) begin
            xs_q <= '0;
        end else if (busy_rd) begin
            xs_q <= xs_q + 1'b1;
        end
    end
endmodule

// File: rtl/ddr_refresh_sched.sv
// Refresh scheduler top. Converts the timing parameters to cycles and
// sequences precharge-all / auto-refresh requests and self-refresh
// entry and exit. Assumes the arbiter only grants while req_o is high
// and puts the command lines on the bus in the grant cycle.
module ddr_refresh_sched
    import ddr_refresh_sched_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 20000,
    parameter int REFI_NS       = 7800,
    parameter int RFC_NS        = 75,
    parameter int RP_NS         = 20,
    parameter int XSNR_NS       = 75,
    parameter int XSRD_CYC      = 200,
    parameter int MAX_OWED      = 8,
    parameter int LAZY_LEVEL    = 4,
    localparam int OW           = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_i,
    input  logic          idle_i,
    input  logic          sr_want_i,
    output logic          req_o,
    output logic          urgent_o,
    output logic          cmd_cs_n_o,
    output logic          cmd_ras_n_o,
    output logic          cmd_cas_n_o,
    output logic          cmd_we_n_o,
    output logic          cmd_a10_o,
    output logic          cke_o,
    output logic          hold_act_o,
    output logic          hold_rd_o,
    output logic [OW-1:0] owed_o
);
    localparam int REFI_CYC = (REFI_NS * 1000) / CLK_PERIOD_PS;
    localparam int RFC_CYC  = (RFC_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RP_CYC   = (RP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int XSNR_CYC = (XSNR_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int WW       = $clog2(RP_CYC + RFC_CYC + 1);
    localparam int RP_LOAD  = (RP_CYC >= 1) ? RP_CYC - 1 : 0;
    localparam int RFC_LOAD = (RFC_CYC >= 2) ? RFC_CYC - 2 : 0;

    rs_state_e     state_q;
    logic [WW-1:0] wcnt_q;
    logic          tick;
    logic          xs_nonrd;
    logic          xs_rd;
    logic          req_pre;
    logic          req_ref;
    logic          ar_done;
    logic          sr_exit;
    logic          start_ar;
    ddr_cmd_t      cmd;

    assign req_pre  = (state_q == ST_PRE_AR) || (state_q == ST_PRE_SR);
    assign req_ref  = ((state_q == ST_REF_AR) || (state_q == ST_ENT_SR)) && (wcnt_q == '0);
    assign ar_done  = (state_q == ST_REF_AR) && (wcnt_q == '0) && grant_i;
    assign sr_exit  = (state_q == ST_SELF) && !sr_want_i;
    assign start_ar = (owed_o >= OW'(LAZY_LEVEL)) || (idle_i && (owed_o != '0));

    refi_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state_q == ST_SELF),
        .tick  (tick)
    );

    owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sr_exit),
        .inc   (tick),
        .dec   (ar_done),
        .owed  (owed_o)
    );

    exit_window #(.XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) u_exit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (sr_exit),
        .busy_nonrd (xs_nonrd),
        .busy_rd    (xs_rd)
    );

    // Sequence the refresh and self-refresh commands and their waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!xs_nonrd) begin
                        if (sr_want_i) begin
                            state_q <= ST_PRE_SR;
                        end else if (start_ar) begin
                            state_q <= ST_PRE_AR;
                        end
                    end
                end
                ST_PRE_AR, ST_PRE_SR: begin
                    if (grant_i) begin
                        state_q <= (state_q == ST_PRE_AR) ? ST_REF_AR : ST_ENT_SR;
                        wcnt_q  <= WW'(RP_LOAD);
                    end
                end
                ST_REF_AR: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end else if (grant_i) begin
                        state_q <= (RFC_CYC >= 2) ? ST_RFC : ST_IDLE;
                        wcnt_q  <= WW'(RFC_LOAD);
                    end
                end
                ST_RFC: begin
                    if (wcnt_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end
                end
                ST_ENT_SR: begin
                    if (wcnt_q != '0) begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end else if (grant_i) begin
                        state_q <= ST_SELF;
                    end
                end
                ST_SELF: begin
                    if (!sr_want_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the request, the command lines and the hold-offs.
    always_comb begin
        cmd = CMD_DESEL;
        if (req_pre) begin
            cmd = CMD_PREALL;
        end else if (req_ref) begin
            cmd = CMD_AREF;
        end
        req_o       = req_pre || req_ref;
        cmd_cs_n_o  = cmd.cs_n;
        cmd_ras_n_o = cmd.ras_n;
        cmd_cas_n_o = cmd.cas_n;
        cmd_we_n_o  = cmd.we_n;
        cmd_a10_o   = cmd.a10;
        urgent_o    = (owed_o == OW'(MAX_OWED));
        cke_o       = !((state_q == ST_SELF) ||
                        ((state_q == ST_ENT_SR) && (wcnt_q == '0) && grant_i));
        hold_act_o  = (state_q == ST_REF_AR) || (state_q == ST_RFC) ||
                      (state_q == ST_ENT_SR) || (state_q == ST_SELF) || xs_nonrd;
        hold_rd_o   = (state_q == ST_SELF) || xs_rd;
    end
endmodule

// File: rtl/ddr_refresh_sched_chk.sv
// Property checker for the refresh scheduler, attached by bind.
// Observes only the top-level ports.
module ddr_refresh_sched_chk #(
    parameter int MAX_OWED = 8,
    parameter int RP_CYC   = 1,
    localparam int OW      = $clog2(MAX_OWED + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          grant_i,
    input logic          req_o,
    input logic          cmd_cs_n_o,
    input logic          cmd_ras_n_o,
    input logic          cmd_cas_n_o,
    input logic          cmd_we_n_o,
    input logic          cmd_a10_o,
    input logic          cke_o,
    input logic          hold_act_o,
    input logic          hold_rd_o,
    input logic [OW-1:0] owed_o
);
    logic [4:0] cmd_bus;
    assign cmd_bus = {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o, cmd_a10_o};

    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        owed_o <= OW'(MAX_OWED)); // R2

    AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_o != $past(owed_o)) && (owed_o != '0) |->
        (owed_o == $past(owed_o) + 1'b1) || (owed_o == $past(owed_o) - 1'b1)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !grant_i |=> req_o); // R8

    AST_CMD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !grant_i |=> $stable(cmd_bus)); // R8

    AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o && $past(!cke_o) |-> !req_o); // R9

    AST_RFC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && grant_i && !cmd_cas_n_o && cke_o |=> hold_act_o && !req_o); // R6

    AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> hold_act_o && hold_rd_o); // R10

    AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> owed_o == '0); // R11

    if (RP_CYC > 1) begin : g_rp_wait
        AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            req_o && grant_i && cmd_a10_o |=> !req_o); // R4
    end
endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk #(
    .MAX_OWED (MAX_OWED),
    .RP_CYC   (RP_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant_i),
    .req_o       (req_o),
    .cmd_cs_n_o  (cmd_cs_n_o),
    .cmd_ras_n_o (cmd_ras_n_o),
    .cmd_cas_n_o (cmd_cas_n_o),
    .cmd_we_n_o  (cmd_we_n_o),
    .cmd_a10_o   (cmd_a10_o),
    .cke_o       (cke_o),
    .hold_act_o  (hold_act_o),
    .hold_rd_o   (hold_rd_o),
    .owed_o      (owed_o)
);

// File: tb/ddr_refresh_sched_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared at every falling edge, plus
// directed scenario checks. Inputs change a quarter period after the
// rising edge, outputs are compared at the falling edge.
module ddr_refresh_sched_tb_top;
    localparam int CLK_PS  = 20000;
    localparam int REFI_NS = 7800;
    localparam int RFC_NS  = 75;
    localparam int RP_NS   = 45;
    localparam int XSNR_NS = 75;
    localparam int XSRD    = 200;
    localparam int MAXO    = 8;
    localparam int LAZY    = 4;
    localparam int REFI    = REFI_NS * 1000 / CLK_PS;
    localparam int RFC     = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RP      = (RP_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int XSNR    = (XSNR_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_i = 1'b0;
    logic idle_i = 1'b0;
    logic sr_want_i = 1'b0;
    logic req_o, urgent_o, cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o, cmd_a10_o;
    logic cke_o, hold_act_o, hold_rd_o;
    logic [3:0] owed_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int gmode = 0;
    bit done = 0;

    // model state: 0 idle,1 pre,2 ref,3 rfc,4 pre-sr,5 ent-sr,6 self
    int m_st = 0, m_w = 0, m_tmr = 0, m_owed = 0, m_xs = XSRD;

    ddr_refresh_sched #(
        .CLK_PERIOD_PS (CLK_PS), .REFI_NS (REFI_NS), .RFC_NS (RFC_NS),
        .RP_NS (RP_NS), .XSNR_NS (XSNR_NS), .XSRD_CYC (XSRD),
        .MAX_OWED (MAXO), .LAZY_LEVEL (LAZY)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .grant_i (grant_i), .idle_i (idle_i),
        .sr_want_i (sr_want_i), .req_o (req_o), .urgent_o (urgent_o),
        .cmd_cs_n_o (cmd_cs_n_o), .cmd_ras_n_o (cmd_ras_n_o),
        .cmd_cas_n_o (cmd_cas_n_o), .cmd_we_n_o (cmd_we_n_o),
        .cmd_a10_o (cmd_a10_o), .cke_o (cke_o), .hold_act_o (hold_act_o),
        .hold_rd_o (hold_rd_o), .owed_o (owed_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Model outputs derived from model state and current inputs.
    function automatic int m_req();
        return (m_st == 1 || m_st == 4 || ((m_st == 2 || m_st == 5) && m_w == 0)) ? 1 : 0;
    endfunction

    // Reference model: advances one cycle per rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_w = 0; m_tmr = 0; m_owed = 0; m_xs = XSRD;
        end else begin
            int tick, dec, nst, nw, ntmr, nowed, nxs;
            bit leave;
            tick  = (m_st != 6 && m_tmr == REFI - 1) ? 1 : 0;
            dec   = (m_st == 2 && m_w == 0 && grant_i) ? 1 : 0;
            leave = (m_st == 6 && !sr_want_i);
            ntmr  = (m_st == 6 || tick == 1) ? 0 : m_tmr + 1;
            nowed = m_owed + tick - dec;
            if (nowed > MAXO) nowed = MAXO;
            if (leave) nowed = 0;
            nxs = leave ? 0 : (m_xs < XSRD ? m_xs + 1 : m_xs);
            nst = m_st; nw = m_w;
            case (m_st)
                0: if (m_xs >= XSNR) begin
                       if (sr_want_i) nst = 4;
                       else if (m_owed >= LAZY || (idle_i && m_owed > 0)) nst = 1;
                   end
                1: if (grant_i) begin nst = 2; nw = RP - 1; end
                4: if (grant_i) begin nst = 5; nw = RP - 1; end
                2: if (m_w > 0) nw = m_w - 1;
                   else if (grant_i) begin
                       if (RFC >= 2) begin nst = 3; nw = RFC - 2; end else nst = 0;
                   end
                3: if (m_w == 0) nst = 0; else nw = m_w - 1;
                5: if (m_w > 0) nw = m_w - 1; else if (grant_i) nst = 6;
                6: if (!sr_want_i) nst = 0;
                default: nst = 0;
            endcase
            m_st = nst; m_w = nw; m_tmr = ntmr; m_owed = nowed; m_xs = nxs;
        end
        if (cyc > 150000 && !done) begin
            nerr++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Arbiter stand-in: grants a quarter period into the cycle.
    always @(posedge clk) begin
        #6;
        grant_i = req_o && (gmode == 1 ||
                  (gmode == 2 && (cmd_cas_n_o || m_tmr == REFI - 1)));
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int rq, isref, ck;
            rq    = m_req();
            isref = (rq == 1 && (m_st == 2 || m_st == 5)) ? 1 : 0;
            ck    = (m_st == 6 || (m_st == 5 && m_w == 0 && grant_i)) ? 0 : 1;
            chk("R4 R8 req", req_o, rq);
            chk("R3 R8 cmd", {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o, cmd_a10_o},
                rq == 0 ? 5'b11110 : (isref == 1 ? 5'b00010 : 5'b00101));
            chk("R1 R5 owed", owed_o, m_owed);
            chk("R2 urgent", urgent_o, m_owed == MAXO ? 1 : 0);
            chk("R9 cke", cke_o, ck);
            chk("R6 hold_act", hold_act_o,
                (m_st == 2 || m_st == 3 || m_st == 5 || m_st == 6 || m_xs < XSNR) ? 1 : 0);
            chk("R10 hold_rd", hold_rd_o, (m_st == 6 || m_xs < XSRD) ? 1 : 0);
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #5 rst_n = 1'b1;
        // reset state
        chk("R8 reset req", req_o, 0);
        chk("R9 reset cke", cke_o, 1);
        chk("R1 reset owed", owed_o, 0);
        chk("R10 reset hold_rd", hold_rd_o, 0);
        chk("R6 reset hold_act", hold_act_o, 0);

        // accrue below the lazy level with no grants
        step(REFI * 3 + 5);
        chk("R1 owed after three intervals", owed_o, 3);
        chk("R3 no request below lazy level", req_o, 0);
        step(REFI);
        chk("R3 request at lazy level", req_o, 1);
        chk("R3 precharge-all a10", cmd_a10_o, 1);
        chk("R3 precharge-all cas_n", cmd_cas_n_o, 1);
        step(REFI * 4);
        chk("R2 credit full", owed_o, 8);
        chk("R2 urgent flag", urgent_o, 1);
        step(REFI * 2);
        chk("R2 saturated at eight", owed_o, 8);

        // grant everything: drain to just below the lazy level
        gmode = 1;
        step(80);
        chk("R5 drained to lazy-1", owed_o, 3);
        chk("R5 no request after drain", req_o, 0);

        // opportunistic drain
        idle_i = 1'b1;
        step(40);
        chk("R7 idle drains to zero", owed_o, 0);
        chk("R7 no request at zero", req_o, 0);
        step(REFI);
        chk("R7 idle keeps credit at zero", owed_o, 0);
        idle_i = 1'b0;

        // tick coinciding with the refresh grant
        gmode = 2;
        step(REFI * 6);
        chk("R5 tick and grant cancel", owed_o, 4);
        gmode = 1;
        step(40);
        chk("R5 grant lowers credit", owed_o, 3);

        // self-refresh chosen over an idle-triggered refresh
        sr_want_i = 1'b1;
        idle_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!cke_o) break;
        end
        chk("R9 cke low on entry refresh", cke_o, 0);
        chk("R9 entry uses refresh encoding", cmd_cas_n_o, 0);
        chk("R12 no auto-refresh before entry", owed_o, 3);
        step(2);
        chk("R9 cke held low", cke_o, 0);
        chk("R9 no request in self-refresh", req_o, 0);
        step(REFI + 10);
        chk("R11 timer frozen in self-refresh", owed_o, 3);

        // exit and hold-off windows
        sr_want_i = 1'b0;
        idle_i = 1'b0;
        step(1);
        chk("R10 cke high after exit", cke_o, 1);
        chk("R11 credit cleared", owed_o, 0);
        chk("R10 non-read hold at exit", hold_act_o, 1);
        step(XSNR - 1);
        chk("R10 non-read hold last cycle", hold_act_o, 1);
        step(1);
        chk("R10 non-read hold released", hold_act_o, 0);
        step(XSRD - XSNR - 1);
        chk("R10 read hold last cycle", hold_rd_o, 1);
        step(1);
        chk("R10 read hold released", hold_rd_o, 0);
        step(REFI - XSRD - 1);
        chk("R11 no tick before full interval", owed_o, 0);
        step(1);
        chk("R11 first tick after restart", owed_o, 1);

        // re-entry request inside the non-read exit window
        sr_want_i = 1'b1;
        step(40);
        chk("R9 back in self-refresh", cke_o, 0);
        sr_want_i = 1'b0;
        step(1);
        sr_want_i = 1'b1;
        step(XSNR - 1);
        chk("R12 no request inside exit window", req_o, 0);
        step(1);
        chk("R12 no request at window end", req_o, 0);
        step(1);
        chk("R12 precharge after window", req_o, 1);
        chk("R12 precharge-all a10", cmd_a10_o, 1);
        sr_want_i = 1'b0;
        step(300);

        done = 1;
        finish_run();
    end
endmodule